// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps dispatched instructions in program order so that they can finish in any order and still update architectural state in order. That in-order update is what makes exceptions precise. Every allocated instruction gets a slot. The slot index is returned as the instruction's destination tag. Each slot records:

- the operation kind;
- the destination kind and its register number or memory address;
- the result value;
- a done flag, an exception flag and a mispredict flag.

Execution units report results back by tag. A result stays inside the buffer until its slot becomes the oldest one and retires. Only then does it drive the register-file write port or the memory write port.

The oldest slot retires only after it has been reported done, and at most one slot retires per cycle. Two conditions at the oldest slot flush the whole buffer and return both pointers to slot 0:

- a reported exception, which is signalled with its tag and writes nothing;
- a branch that was reported mispredicted.

Occupancy is kept with an extra wrap bit on the head and tail pointers. A full buffer and an empty buffer can therefore be told apart without a separate counter.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: `occupancy` is 0, `alloc_ready` is 1, `alloc_tag` is 0, and `reg_we`, `mem_we`, `excp_valid` and `flush` are all 0.
- R2: An allocation is accepted on a clock edge where `alloc_valid` and `alloc_ready` are both 1. The tag it receives is the `alloc_tag` value seen before that edge. Successive tags count up by one modulo DEPTH, and `occupancy` rises by one.
- R3: Once DEPTH slots are held, `alloc_ready` is 0. A further `alloc_valid` changes neither `occupancy` nor `alloc_tag`.
- R4: A completion (`cmp_valid`) stores `cmp_value` and marks the slot named by `cmp_tag` done, along with its exception and mispredict flags. A completion whose tag names an unallocated slot is ignored: no retirement follows and `occupancy` is unchanged.
- R5: Only the oldest slot retires, and only once it is done. Later slots that completed first wait. Retirement runs in allocation order at one slot per cycle, and each retirement lowers `occupancy` by one.
- R6: The destination kind decides the write on retirement. Encoding 0 (none) writes nothing. Encoding 1 (register) drives `reg_we` with `reg_idx` equal to the destination and `reg_data` equal to the value. Encoding 2 (memory) drives `mem_we` with `mem_addr` and `mem_data`.
- R7: If the oldest slot is done with its exception flag set, the cycle shows `excp_valid`=1, `excp_tag` equal to its slot, `flush`=1, `alloc_ready`=0 and no write. After the next edge `occupancy` is 0 and `alloc_tag` is 0.
- R8: Operation kind encoding is 0 ALU, 1 load, 2 store, 3 branch. A branch that is done at the head and flagged mispredicted raises `flush` without a write. All younger slots are discarded, even ones already done. A correctly predicted branch retires with no write and no flush.
- R9: `occupancy` always equals the number of allocated slots that have not yet retired or been flushed, and it is never above DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate a slot |
| alloc_kind | input | 2 | Operation kind (0 ALU, 1 load, 2 store, 3 branch) |
| alloc_dkind | input | 2 | Destination kind (0 none, 1 register, 2 memory) |
| alloc_dst | input | DST_W | Register number or memory address |
| alloc_ready | output | 1 | A slot is free and no flush is in progress |
| alloc_tag | output | IDX_W | Tag the next accepted allocation receives |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | IDX_W | Slot being completed |
| cmp_value | input | DATA_W | Result value |
| cmp_excp | input | 1 | Completed instruction raised an exception |
| cmp_mispred | input | 1 | Completed branch was mispredicted |
| reg_we | output | 1 | Register file write at retirement |
| reg_idx | output | DST_W | Register written |
| reg_data | output | DATA_W | Value written to the register |
| mem_we | output | 1 | Memory write at retirement |
| mem_addr | output | DST_W | Memory address written |
| mem_data | output | DATA_W | Value written to memory |
| excp_valid | output | 1 | Precise exception at the oldest slot |
| excp_tag | output | IDX_W | Slot that raised the exception |
| flush | output | 1 | Whole buffer is discarded at the next edge |
| occupancy | output | IDX_W+1 | Number of slots in use |

## Verification
A corrupted head or tail pointer shows up at the ports within a cycle. It either puts `occupancy` at the wrong value or makes the retired register index and data come out in the wrong order. A done flag that is set early or lost shows up as a write on `reg_we` or `mem_we` in the wrong cycle. A completion that reaches the wrong slot, or is not ignored when it should be, has the same effect. A flush that leaves slots behind is caught one cycle later, as a non-zero `occupancy` or as a write from a slot that should have been discarded.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_LOAD   = 2'd1,
    K_STORE  = 2'd2,
    K_BRANCH = 2'd3
  } op_kind_t;

  typedef enum logic [1:0] {
    D_NONE = 2'd0,
    D_REG  = 2'd1,
    D_MEM  = 2'd2
  } dst_kind_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic [IDX_W:0]   count
);
  localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(DEPTH);

  logic [IDX_W:0] head_q, tail_q;

  // Pointer step with wrap bit; DEPTH is a power of two.
  function automatic logic [IDX_W:0] bump(input logic [IDX_W:0] p);
    return p + (IDX_W+1)'(1);
  endfunction

  function automatic logic [IDX_W:0] span(input logic [IDX_W:0] h, input logic [IDX_W:0] t);
    return t - h;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc_fire)  tail_q <= bump(tail_q);
      if (retire_fire) head_q <= bump(head_q);
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign count    = span(head_q, tail_q);
  assign full     = (count == FULL_CNT);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  a_r3_no_grow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_fire);
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int DST_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic [1:0]        alloc_kind,
  input  logic [1:0]        alloc_dkind,
  input  logic [DST_W-1:0]  alloc_dst,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_excp,
  input  logic              cmp_mispred,
  input  logic              retire_fire,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic              flush,
  output logic              head_valid,
  output logic              head_done,
  output logic              head_excp,
  output logic              head_mispred,
  output logic [1:0]        head_kind,
  output logic [1:0]        head_dkind,
  output logic [DST_W-1:0]  head_dst,
  output logic [DATA_W-1:0] head_value
);
  logic [DEPTH-1:0]  valid_q, done_q, excp_q, misp_q;
  logic [DEPTH-1:0]  slot_alloc, slot_cmp, slot_retire;
  logic [1:0]        kind_q  [DEPTH];
  logic [1:0]        dkind_q [DEPTH];
  logic [DST_W-1:0]  dst_q   [DEPTH];
  logic [DATA_W-1:0] val_q   [DEPTH];

  // Per-slot event decode, brought out as named wires.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_alloc[g]  = alloc_fire  && (tail_idx == IDX_W'(g));
    assign slot_cmp[g]    = cmp_valid   && (cmp_tag  == IDX_W'(g)) && valid_q[g];
    assign slot_retire[g] = retire_fire && (head_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      done_q  <= '0;
      excp_q  <= '0;
      misp_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i]  <= '0;
        dkind_q[i] <= '0;
        dst_q[i]   <= '0;
        val_q[i]   <= '0;
      end
    end else if (flush) begin
      valid_q <= '0;
      done_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (slot_alloc[i]) begin
          valid_q[i] <= 1'b1;
          done_q[i]  <= 1'b0;
          excp_q[i]  <= 1'b0;
          misp_q[i]  <= 1'b0;
          kind_q[i]  <= alloc_kind;
          dkind_q[i] <= alloc_dkind;
          dst_q[i]   <= alloc_dst;
        end else if (slot_retire[i]) begin
          valid_q[i] <= 1'b0;
          done_q[i]  <= 1'b0;
        end else if (slot_cmp[i]) begin
          done_q[i] <= 1'b1;
          excp_q[i] <= cmp_excp;
          misp_q[i] <= cmp_mispred;
          val_q[i]  <= cmp_value;
        end
      end
    end
  end

  assign head_valid   = valid_q[head_idx];
  assign head_done    = done_q[head_idx];
  assign head_excp    = excp_q[head_idx];
  assign head_mispred = misp_q[head_idx];
  assign head_kind    = kind_q[head_idx];
  assign head_dkind   = dkind_q[head_idx];
  assign head_dst     = dst_q[head_idx];
  assign head_value   = val_q[head_idx];

  a_r4_done_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q & ~valid_q) == '0);
  a_r2_alloc_into_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_alloc) && ((slot_alloc & valid_q) == '0));
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter int DATA_W = 16,
  parameter int DST_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic              head_done,
  input  logic              head_excp,
  input  logic              head_mispred,
  input  logic [1:0]        head_kind,
  input  logic [1:0]        head_dkind,
  input  logic [DST_W-1:0]  head_dst,
  input  logic [DATA_W-1:0] head_value,
  output logic              retire_fire,
  output logic              reg_we,
  output logic [DST_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_data,
  output logic              mem_we,
  output logic [DST_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              excp_valid,
  output logic              flush
);
  import rob_pkg::*;

  logic clean, redirect;

  assign retire_fire = head_valid && head_done;
  assign clean       = retire_fire && !head_excp;
  assign redirect    = clean && (head_kind == K_BRANCH) && head_mispred;

  assign reg_we     = clean && (head_dkind == D_REG);
  assign mem_we     = clean && (head_dkind == D_MEM);
  assign reg_idx    = head_dst;
  assign mem_addr   = head_dst;
  assign reg_data   = head_value;
  assign mem_data   = head_value;
  assign excp_valid = retire_fire && head_excp;
  assign flush      = excp_valid || redirect;

  a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, mem_we, excp_valid}));
  a_r5_write_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || mem_we) |-> (head_valid && head_done));
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int DST_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [1:0]        alloc_dkind,
  input  logic [DST_W-1:0]  alloc_dst,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_excp,
  input  logic              cmp_mispred,
  output logic              reg_we,
  output logic [DST_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_data,
  output logic              mem_we,
  output logic [DST_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              excp_valid,
  output logic [IDX_W-1:0]  excp_tag,
  output logic              flush,
  output logic [IDX_W:0]    occupancy
);
  logic              full, alloc_fire, retire_fire;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              head_valid, head_done, head_excp, head_mispred;
  logic [1:0]        head_kind, head_dkind;
  logic [DST_W-1:0]  head_dst;
  logic [DATA_W-1:0] head_value;

  assign alloc_ready = !full && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_idx;
  assign excp_tag    = head_idx;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .retire_fire(retire_fire), .flush(flush),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .count(occupancy)
  );

  rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DST_W(DST_W)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .tail_idx(tail_idx),
    .alloc_kind(alloc_kind), .alloc_dkind(alloc_dkind), .alloc_dst(alloc_dst),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .cmp_excp(cmp_excp), .cmp_mispred(cmp_mispred),
    .retire_fire(retire_fire), .head_idx(head_idx), .flush(flush),
    .head_valid(head_valid), .head_done(head_done), .head_excp(head_excp),
    .head_mispred(head_mispred), .head_kind(head_kind), .head_dkind(head_dkind),
    .head_dst(head_dst), .head_value(head_value)
  );

  rob_retire #(.DATA_W(DATA_W), .DST_W(DST_W)) u_retire (
    .clk(clk), .rst_n(rst_n),
    .head_valid(head_valid), .head_done(head_done), .head_excp(head_excp),
    .head_mispred(head_mispred), .head_kind(head_kind), .head_dkind(head_dkind),
    .head_dst(head_dst), .head_value(head_value),
    .retire_fire(retire_fire),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_data(reg_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .excp_valid(excp_valid), .flush(flush)
  );

  // Occupancy from the pointers must agree with the slot flags.
  a_r9_occ_matches_head: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy != '0) == head_valid);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occupancy == '0) && !reg_we && !mem_we);
endmodule

// File: tb/reorder_buffer_bench.sv
`timescale 1ns/1ps
module reorder_buffer_bench;
  localparam int DEPTH = 8, DATA_W = 16, DST_W = 8, IDX_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, cmp_valid = 0, cmp_excp = 0, cmp_mispred = 0;
  logic [1:0] alloc_kind = 0, alloc_dkind = 0;
  logic [DST_W-1:0] alloc_dst = 0;
  logic [IDX_W-1:0] cmp_tag = 0;
  logic [DATA_W-1:0] cmp_value = 0;
  logic alloc_ready, reg_we, mem_we, excp_valid, flush;
  logic [IDX_W-1:0] alloc_tag, excp_tag;
  logic [DST_W-1:0] reg_idx, mem_addr;
  logic [DATA_W-1:0] reg_data, mem_data;
  logic [IDX_W:0] occupancy;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  reorder_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DST_W(DST_W)) u_reorder_buffer (
    .clk, .rst_n, .alloc_valid, .alloc_kind, .alloc_dkind, .alloc_dst,
    .alloc_ready, .alloc_tag, .cmp_valid, .cmp_tag, .cmp_value, .cmp_excp,
    .cmp_mispred, .reg_we, .reg_idx, .reg_data, .mem_we, .mem_addr, .mem_data,
    .excp_valid, .excp_tag, .flush, .occupancy
  );

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic alloc(input logic [1:0] k, input logic [1:0] dk, input logic [DST_W-1:0] d);
    alloc_valid = 1; alloc_kind = k; alloc_dkind = dk; alloc_dst = d;
    tick();
    alloc_valid = 0;
  endtask

  task automatic complete(input int t, input int v, input logic ex, input logic mp);
    cmp_valid = 1; cmp_tag = IDX_W'(t); cmp_value = DATA_W'(v);
    cmp_excp = ex; cmp_mispred = mp;
    tick();
    cmp_valid = 0; cmp_excp = 0; cmp_mispred = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    check("R1 occupancy", occupancy, 0);
    check("R1 alloc_ready", alloc_ready, 1);
    check("R1 alloc_tag", alloc_tag, 0);
    check("R1 no outputs", {reg_we, mem_we, excp_valid, flush}, 0);

    // R2 fill every slot, tags count up
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 tag", alloc_tag, i);
      alloc(2'd0, 2'd1, DST_W'(i + 1));
      check("R2 occupancy", occupancy, i + 1);
    end
    // R3 full
    check("R3 alloc_ready low", alloc_ready, 0);
    alloc(2'd0, 2'd1, 8'h77);
    check("R3 occupancy held", occupancy, DEPTH);
    check("R3 tag held", alloc_tag, 0);

    // R5 complete youngest first; nothing retires until head done
    for (int t = DEPTH - 1; t >= 1; t--) begin
      complete(t, 100 + t, 0, 0);
      check("R5 no early retire", {reg_we, mem_we}, 0);
    end
    check("R5 occupancy waits", occupancy, DEPTH);
    complete(0, 100, 0, 0);
    for (int i = 0; i < DEPTH; i++) begin
      check("R5 in-order reg_we", reg_we, 1);
      check("R6 reg_idx", reg_idx, i + 1);
      check("R6 reg_data", reg_data, 100 + i);
      check("R9 occupancy drains", occupancy, DEPTH - i);
      tick();
    end
    check("R9 empty after drain", occupancy, 0);
    check("R5 idle after drain", reg_we, 0);

    // R4 stale completion ignored; R6 store; R8 correct branch
    alloc(2'd2, 2'd2, 8'h40);   // tag 0 store
    alloc(2'd3, 2'd0, 8'h00);   // tag 1 branch
    complete(5, 16'h1234, 0, 0);
    check("R4 stale ignored occ", occupancy, 2);
    check("R4 stale ignored write", {reg_we, mem_we}, 0);
    complete(1, 0, 0, 0);
    check("R5 head not done", {reg_we, mem_we}, 0);
    complete(0, 16'hBEEF, 0, 0);
    check("R6 mem_we", mem_we, 1);
    check("R6 mem_addr", mem_addr, 8'h40);
    check("R6 mem_data", mem_data, 16'hBEEF);
    check("R6 store no reg", reg_we, 0);
    tick();
    check("R8 branch no write", {reg_we, mem_we, excp_valid}, 0);
    check("R8 good branch no flush", flush, 0);
    check("R8 branch at head", occupancy, 1);
    tick();
    check("R8 branch retired", occupancy, 0);

    // R7 exception at tag 3 (head is now 2)
    alloc(2'd0, 2'd1, 8'd10);
    alloc(2'd1, 2'd1, 8'd11);
    alloc(2'd0, 2'd1, 8'd12);
    complete(4, 44, 0, 0);
    complete(3, 33, 1, 0);
    complete(2, 7, 0, 0);
    check("R7 older retires", reg_we, 1);
    check("R7 older idx", reg_idx, 10);
    check("R7 older data", reg_data, 7);
    tick();
    check("R7 excp_valid", excp_valid, 1);
    check("R7 excp_tag", excp_tag, 3);
    check("R7 flush", flush, 1);
    check("R7 no write", {reg_we, mem_we}, 0);
    check("R7 alloc blocked", alloc_ready, 0);
    tick();
    check("R7 empty", occupancy, 0);
    check("R7 tag reset", alloc_tag, 0);
    check("R7 younger dropped", {reg_we, mem_we, excp_valid}, 0);

    // R8 mispredicted branch discards done younger slots
    alloc(2'd3, 2'd0, 8'd0);
    alloc(2'd0, 2'd1, 8'd20);
    alloc(2'd1, 2'd1, 8'd21);
    complete(1, 55, 0, 0);
    complete(2, 66, 0, 0);
    complete(0, 0, 0, 1);
    check("R8 flush", flush, 1);
    check("R8 no write", {reg_we, mem_we, excp_valid}, 0);
    tick();
    check("R8 empty", occupancy, 0);
    check("R8 younger discarded", {reg_we, mem_we}, 0);
    complete(1, 99, 0, 0);
    check("R4 post-flush ignored", {occupancy, reg_we}, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule